// File: doc/BRIEF.md
# DMA Controller Register File

This block is the software-visible control plane of a two-dimensional memory-to-memory DMA engine. Software reaches it through an AXI4-Lite slave port with 32-bit data and 11-bit byte addresses. The block holds identification words, a scratch word, interrupt mask and pending state, an enable bit, and one transfer descriptor. The descriptor carries source and destination addresses, X and Y lengths, source and destination strides, and three mode flags.

A write of one to the submit word offers the descriptor to the transfer engine through a valid/ready handshake. Each accepted descriptor takes the next transfer ID from a small ring and marks that ID busy. The engine returns end-of-transfer responses in submission order, and each one frees the oldest busy ID. Two interrupt sources, descriptor accepted and transfer complete, latch into a pending word that software clears by writing ones.

The hardware keeps the length and stride fields aligned, so software can never set up lengths that the two sides of the data path would round differently. The X length always has its low bits set to one. Address and stride fields always have their low beat-offset bits cleared. Software writes zero to the X length and reads it back to learn the length granule.

The AXI side uses two state machines. The write machine has the states WR_IDLE, WR_GOT_ADDR, WR_GOT_DATA and WR_RESP. From WR_IDLE it moves to WR_RESP when address and data arrive together, to WR_GOT_ADDR when only the address arrives, and to WR_GOT_DATA when only the data arrives. WR_GOT_ADDR moves to WR_RESP when the data arrives, and WR_GOT_DATA moves to WR_RESP when the address arrives. WR_RESP returns to WR_IDLE when the response is taken. The read machine moves from RD_IDLE to RD_DATA when an address is accepted, and from RD_DATA back to RD_IDLE when the data is taken.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, the words read as follows: 0x000 = 0x00040361, 0x00C = 0x444D4143, 0x010 = 0x00002101, 0x080 (interrupt mask) = 0x3, 0x40C (flags) = 0x3, 0x418 (X length) = 0x3. Every other implemented word reads zero, and irq, req_valid and ctrl_enable are low.
- R2: The word at 0x008 stores any 32-bit value written to it. Writes to 0x000, 0x00C and 0x010 leave their values unchanged.
- R3: The X length at 0x418 is 24 bits wide. Its low LEN_ALIGN bits (two by default) always read as one, so a write of zero reads back 0x3 and a write of 0xFFFFFFFF reads back 0x00FFFFFF. The Y length at 0x41C is a plain 24-bit field.
- R4: The destination address (0x410) and source address (0x414) are 32 bits wide. The destination stride (0x420) and source stride (0x424) are 24 bits wide. All four keep their low BEAT_W bits (one by default) at zero, whatever is written.
- R5: The flags word at 0x40C holds 3 bits and drives req_flags.
- R6: An address that is not implemented reads as zero and ignores writes. Every write response and every read response is OKAY (00).
- R7: A write may present its address first, its data first, or both together. Exactly one write response follows once both have been taken. Read data is valid in the cycle after the read address is accepted, and it stays stable until it is taken.
- R8: Bit 0 of 0x400 drives ctrl_enable. Writing 1 to bit 0 of 0x408 requests a submission, and writing 0 there has no effect. req_valid is high while a submission is requested, ctrl_enable is high and the next ID is free. The word 0x408 reads 1 until the descriptor is accepted, then reads 0.
- R9: Each acceptance (req_valid and req_ready both high) advances the ID at 0x404 by one, modulo 4, and sets bit (31 - id) of 0x428 for the ID just used. A response with rsp_valid and rsp_eot both high clears the bit of the oldest busy ID. A response with rsp_eot low changes nothing.
- R10: Bit 0 of 0x084 latches on an acceptance and bit 1 latches on a completing response, whatever the mask holds. Writing a one to a bit of 0x084 clears that bit. 0x088 reads the pending bits with the masked bits removed (a mask bit of 1 masks). irq is high when any bit of 0x088 is set.
- R11: When a pending bit is set by its event in the same cycle that a write clears it, the bit stays set.
- R12: Reset returns every register to its R1 value, even after all writable words have been written with all ones.
- R13: When all four IDs are busy, a requested submission waits with req_valid low. It is accepted once the oldest ID completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| axil_awvalid | input | 1 | Write address valid |
| axil_awaddr | input | 11 | Write byte address |
| axil_awready | output | 1 | Write address ready |
| axil_wvalid | input | 1 | Write data valid |
| axil_wdata | input | 32 | Write data |
| axil_wready | output | 1 | Write data ready |
| axil_bvalid | output | 1 | Write response valid |
| axil_bready | input | 1 | Write response ready |
| axil_bresp | output | 2 | Write response code |
| axil_arvalid | input | 1 | Read address valid |
| axil_araddr | input | 11 | Read byte address |
| axil_arready | output | 1 | Read address ready |
| axil_rvalid | output | 1 | Read data valid |
| axil_rready | input | 1 | Read data ready |
| axil_rdata | output | 32 | Read data |
| axil_rresp | output | 2 | Read response code |
| ctrl_enable | output | 1 | Engine enable |
| req_valid | output | 1 | Descriptor offered |
| req_ready | input | 1 | Descriptor taken by the engine |
| req_dst_addr | output | 32 | Destination start address |
| req_src_addr | output | 32 | Source start address |
| req_x_len | output | 24 | Row length |
| req_y_len | output | 24 | Row count field |
| req_dst_stride | output | 24 | Destination row stride |
| req_src_stride | output | 24 | Source row stride |
| req_flags | output | 3 | Mode flags |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_eot | input | 1 | Response marks end of transfer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume an AXI4-Lite master that holds each valid until its ready and keeps its address and data stable while waiting. They also assume that the engine sends a completing response only while some ID is busy, and that it answers in submission order. The bench drives every channel through tasks that hold valid until the handshake. It issues end-of-transfer pulses only after an acceptance that has not yet completed. It lines up the clear-versus-set collision by starting the write and the response pulse on the same falling edge.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int unsigned CSR_AW = 11;
    localparam int unsigned CSR_DW = 32;
    localparam int unsigned IRQ_N  = 2;

    localparam logic [CSR_AW-1:0] OFS_VERSION    = 11'h000;
    localparam logic [CSR_AW-1:0] OFS_SCRATCH    = 11'h008;
    localparam logic [CSR_AW-1:0] OFS_MAGIC      = 11'h00C;
    localparam logic [CSR_AW-1:0] OFS_IFACE      = 11'h010;
    localparam logic [CSR_AW-1:0] OFS_IRQ_MASK   = 11'h080;
    localparam logic [CSR_AW-1:0] OFS_IRQ_PEND   = 11'h084;
    localparam logic [CSR_AW-1:0] OFS_IRQ_STAT   = 11'h088;
    localparam logic [CSR_AW-1:0] OFS_CTRL       = 11'h400;
    localparam logic [CSR_AW-1:0] OFS_XFER_ID    = 11'h404;
    localparam logic [CSR_AW-1:0] OFS_SUBMIT     = 11'h408;
    localparam logic [CSR_AW-1:0] OFS_FLAGS      = 11'h40C;
    localparam logic [CSR_AW-1:0] OFS_DST_ADDR   = 11'h410;
    localparam logic [CSR_AW-1:0] OFS_SRC_ADDR   = 11'h414;
    localparam logic [CSR_AW-1:0] OFS_X_LEN      = 11'h418;
    localparam logic [CSR_AW-1:0] OFS_Y_LEN      = 11'h41C;
    localparam logic [CSR_AW-1:0] OFS_DST_STRIDE = 11'h420;
    localparam logic [CSR_AW-1:0] OFS_SRC_STRIDE = 11'h424;
    localparam logic [CSR_AW-1:0] OFS_BUSY_IDS   = 11'h428;

    localparam logic [CSR_DW-1:0] VERSION_WORD = 32'h0004_0361;
    localparam logic [CSR_DW-1:0] MAGIC_WORD   = 32'h444D_4143;
    localparam logic [CSR_DW-1:0] IFACE_WORD   = 32'h0000_2101;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {WR_IDLE, WR_GOT_ADDR, WR_GOT_DATA, WR_RESP} wr_state_t;
    typedef enum logic {RD_IDLE, RD_DATA} rd_state_t;
endpackage

// File: rtl/dma_csr_axil_if.sv
module dma_csr_axil_if
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    input  logic [CSR_AW-1:0] awaddr,
    output logic              awready,
    input  logic              wvalid,
    input  logic [CSR_DW-1:0] wdata,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    input  logic              arvalid,
    input  logic [CSR_AW-1:0] araddr,
    output logic              arready,
    output logic              rvalid,
    input  logic              rready,
    output logic [CSR_DW-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              wr_en,
    output logic [CSR_AW-1:0] wr_addr,
    output logic [CSR_DW-1:0] wr_data,
    output logic [CSR_AW-1:0] rd_addr,
    input  logic [CSR_DW-1:0] rd_word
);
    wr_state_t wr_q, wr_d;
    rd_state_t rd_q, rd_d;
    logic [CSR_AW-1:0] aw_q;
    logic [CSR_DW-1:0] wd_q;
    logic [CSR_DW-1:0] rdata_q;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= WR_IDLE;
            rd_q <= RD_IDLE;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end

    // next-state logic
    always_comb begin
        wr_d = wr_q;
        unique case (wr_q)
            WR_IDLE: begin
                if (awvalid && wvalid) wr_d = WR_RESP;
                else if (awvalid)      wr_d = WR_GOT_ADDR;
                else if (wvalid)       wr_d = WR_GOT_DATA;
            end
            WR_GOT_ADDR: if (wvalid)  wr_d = WR_RESP;
            WR_GOT_DATA: if (awvalid) wr_d = WR_RESP;
            WR_RESP:     if (bready)  wr_d = WR_IDLE;
            default:                  wr_d = WR_IDLE;
        endcase
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE: if (arvalid) rd_d = RD_DATA;
            RD_DATA: if (rready)  rd_d = RD_IDLE;
            default:              rd_d = RD_IDLE;
        endcase
    end

    // captured address, data and read word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aw_q    <= '0;
            wd_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (awvalid && awready) aw_q <= awaddr;
            if (wvalid && wready)   wd_q <= wdata;
            if (arvalid && arready) rdata_q <= rd_word;
        end
    end

    // outputs
    always_comb begin
        awready = (wr_q == WR_IDLE) || (wr_q == WR_GOT_DATA);
        wready  = (wr_q == WR_IDLE) || (wr_q == WR_GOT_ADDR);
        bvalid  = (wr_q == WR_RESP);
        bresp   = RESP_OKAY;
        wr_en   = (wr_d == WR_RESP) && (wr_q != WR_RESP);
        wr_addr = (wr_q == WR_GOT_ADDR) ? aw_q : awaddr;
        wr_data = (wr_q == WR_GOT_DATA) ? wd_q : wdata;
        arready = (rd_q == RD_IDLE);
        rvalid  = (rd_q == RD_DATA);
        rdata   = rdata_q;
        rresp   = RESP_OKAY;
        rd_addr = araddr;
    end

    // R7: a write response waits for its ready
    a_r7_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R7: exactly one response per write
    a_r7_single_bresp: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && bready |=> !bvalid);
    // R7: read data held until taken
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq
    import dma_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] evt,
    input  logic             mask_we,
    input  logic             pend_we,
    input  logic [IRQ_N-1:0] wbits,
    output logic [IRQ_N-1:0] mask_q,
    output logic [IRQ_N-1:0] pend_q,
    output logic             irq
);
    for (genvar g = 0; g < IRQ_N; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b1;
                pend_q[g] <= 1'b0;
            end else begin
                if (mask_we) mask_q[g] <= wbits[g];
                pend_q[g] <= (pend_q[g] && !(pend_we && wbits[g])) || evt[g];
            end
        end

        // R11: an event beats a same-cycle clear
        a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> pend_q[g]);
        // R10: write-one-to-clear
        a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            pend_we && wbits[g] && !evt[g] |=> !pend_q[g]);
    end

    assign irq = |(pend_q & ~mask_q);
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dma_csr_pkg::*;
#(
    parameter int unsigned LEN_W     = 24,
    parameter int unsigned LEN_ALIGN = 2,
    parameter int unsigned BEAT_W    = 1,
    parameter int unsigned ID_W      = 2,
    parameter int unsigned FLAG_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_AW-1:0] wr_addr,
    input  logic [CSR_DW-1:0] wr_data,
    input  logic [CSR_AW-1:0] rd_addr,
    output logic [CSR_DW-1:0] rd_word,
    input  logic [IRQ_N-1:0]  irq_mask,
    input  logic [IRQ_N-1:0]  irq_pend,
    output logic              mask_we,
    output logic              pend_we,
    output logic [IRQ_N-1:0]  irq_evt,
    output logic              ctrl_enable,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CSR_DW-1:0] req_dst_addr,
    output logic [CSR_DW-1:0] req_src_addr,
    output logic [LEN_W-1:0]  req_x_len,
    output logic [LEN_W-1:0]  req_y_len,
    output logic [LEN_W-1:0]  req_dst_stride,
    output logic [LEN_W-1:0]  req_src_stride,
    output logic [FLAG_W-1:0] req_flags,
    input  logic              rsp_valid,
    input  logic              rsp_eot
);
    localparam int unsigned NIDS = 1 << ID_W;
    localparam logic [LEN_W-1:0]  LEN_FORCE = LEN_W'((1 << LEN_ALIGN) - 1);
    localparam logic [LEN_W-1:0]  STR_KEEP  = ~LEN_W'((1 << BEAT_W) - 1);
    localparam logic [CSR_DW-1:0] ADR_KEEP  = ~CSR_DW'((1 << BEAT_W) - 1);
    localparam logic [FLAG_W-1:0] FLAG_RST  = FLAG_W'(3);

    logic [CSR_AW-1:0] wr_ofs, rd_ofs;
    logic [CSR_DW-1:0] scratch_q, busy_word;
    logic              submit_q, accept, finish;
    logic [ID_W-1:0]   next_id_q, done_id_q;
    logic [NIDS-1:0]   busy_q, busy_d;

    assign wr_ofs = wr_addr & ~CSR_AW'(3);
    assign rd_ofs = rd_addr & ~CSR_AW'(3);

    function automatic logic hit(input logic [CSR_AW-1:0] ofs);
        return wr_en && (wr_ofs == ofs);
    endfunction

    assign accept    = req_valid && req_ready;
    assign finish    = rsp_valid && rsp_eot;
    assign req_valid = submit_q && ctrl_enable && !busy_q[next_id_q];
    assign irq_evt   = {finish, accept};
    assign mask_we   = hit(OFS_IRQ_MASK);
    assign pend_we   = hit(OFS_IRQ_PEND);

    always_comb begin
        for (int k = 0; k < NIDS; k++) begin
            busy_d[k] = (busy_q[k] && !(finish && done_id_q == ID_W'(k)))
                     || (accept && next_id_q == ID_W'(k));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q      <= '0;
            ctrl_enable    <= 1'b0;
            submit_q       <= 1'b0;
            req_flags      <= FLAG_RST;
            req_dst_addr   <= '0;
            req_src_addr   <= '0;
            req_x_len      <= LEN_FORCE;
            req_y_len      <= '0;
            req_dst_stride <= '0;
            req_src_stride <= '0;
            next_id_q      <= '0;
            done_id_q      <= '0;
            busy_q         <= '0;
        end else begin
            if (hit(OFS_SCRATCH))    scratch_q      <= wr_data;
            if (hit(OFS_CTRL))       ctrl_enable    <= wr_data[0];
            if (hit(OFS_FLAGS))      req_flags      <= wr_data[FLAG_W-1:0];
            if (hit(OFS_DST_ADDR))   req_dst_addr   <= wr_data & ADR_KEEP;
            if (hit(OFS_SRC_ADDR))   req_src_addr   <= wr_data & ADR_KEEP;
            if (hit(OFS_X_LEN))      req_x_len      <= wr_data[LEN_W-1:0] | LEN_FORCE;
            if (hit(OFS_Y_LEN))      req_y_len      <= wr_data[LEN_W-1:0];
            if (hit(OFS_DST_STRIDE)) req_dst_stride <= wr_data[LEN_W-1:0] & STR_KEEP;
            if (hit(OFS_SRC_STRIDE)) req_src_stride <= wr_data[LEN_W-1:0] & STR_KEEP;
            submit_q <= (submit_q && !accept) || (hit(OFS_SUBMIT) && wr_data[0]);
            if (accept) next_id_q <= next_id_q + ID_W'(1);
            if (finish) done_id_q <= done_id_q + ID_W'(1);
            busy_q <= busy_d;
        end
    end

    always_comb begin
        busy_word = '0;
        for (int k = 0; k < NIDS; k++) busy_word[CSR_DW-1-k] = busy_q[k];
        case (rd_ofs)
            OFS_VERSION:    rd_word = VERSION_WORD;
            OFS_SCRATCH:    rd_word = scratch_q;
            OFS_MAGIC:      rd_word = MAGIC_WORD;
            OFS_IFACE:      rd_word = IFACE_WORD;
            OFS_IRQ_MASK:   rd_word = CSR_DW'(irq_mask);
            OFS_IRQ_PEND:   rd_word = CSR_DW'(irq_pend);
            OFS_IRQ_STAT:   rd_word = CSR_DW'(irq_pend & ~irq_mask);
            OFS_CTRL:       rd_word = CSR_DW'(ctrl_enable);
            OFS_XFER_ID:    rd_word = CSR_DW'(next_id_q);
            OFS_SUBMIT:     rd_word = CSR_DW'(submit_q);
            OFS_FLAGS:      rd_word = CSR_DW'(req_flags);
            OFS_DST_ADDR:   rd_word = req_dst_addr;
            OFS_SRC_ADDR:   rd_word = req_src_addr;
            OFS_X_LEN:      rd_word = CSR_DW'(req_x_len);
            OFS_Y_LEN:      rd_word = CSR_DW'(req_y_len);
            OFS_DST_STRIDE: rd_word = CSR_DW'(req_dst_stride);
            OFS_SRC_STRIDE: rd_word = CSR_DW'(req_src_stride);
            OFS_BUSY_IDS:   rd_word = busy_word;
            default:        rd_word = '0;
        endcase
    end

    // R8: an offered descriptor stays offered unless enable is rewritten
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !hit(OFS_CTRL) |=> req_valid);
    // R9: the engine only completes a busy ID (input assumption)
    a_r9_eot_matches: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> busy_q[done_id_q]);
    // R9: an accepted ID is marked busy
    a_r9_accept_marks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_q[$past(next_id_q)]);
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int unsigned LEN_W     = 24,
    parameter int unsigned LEN_ALIGN = 2,
    parameter int unsigned BEAT_W    = 1,
    parameter int unsigned ID_W      = 2,
    parameter int unsigned FLAG_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              axil_awvalid,
    input  logic [CSR_AW-1:0] axil_awaddr,
    output logic              axil_awready,
    input  logic              axil_wvalid,
    input  logic [CSR_DW-1:0] axil_wdata,
    output logic              axil_wready,
    output logic              axil_bvalid,
    input  logic              axil_bready,
    output logic [1:0]        axil_bresp,
    input  logic              axil_arvalid,
    input  logic [CSR_AW-1:0] axil_araddr,
    output logic              axil_arready,
    output logic              axil_rvalid,
    input  logic              axil_rready,
    output logic [CSR_DW-1:0] axil_rdata,
    output logic [1:0]        axil_rresp,
    output logic              ctrl_enable,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CSR_DW-1:0] req_dst_addr,
    output logic [CSR_DW-1:0] req_src_addr,
    output logic [LEN_W-1:0]  req_x_len,
    output logic [LEN_W-1:0]  req_y_len,
    output logic [LEN_W-1:0]  req_dst_stride,
    output logic [LEN_W-1:0]  req_src_stride,
    output logic [FLAG_W-1:0] req_flags,
    input  logic              rsp_valid,
    input  logic              rsp_eot,
    output logic              irq
);
    logic              wr_en, mask_we, pend_we;
    logic [CSR_AW-1:0] wr_addr, rd_addr;
    logic [CSR_DW-1:0] wr_data, rd_word;
    logic [IRQ_N-1:0]  irq_mask, irq_pend, irq_evt;

    dma_csr_axil_if u_axil (
        .clk(clk), .rst_n(rst_n),
        .awvalid(axil_awvalid), .awaddr(axil_awaddr), .awready(axil_awready),
        .wvalid(axil_wvalid), .wdata(axil_wdata), .wready(axil_wready),
        .bvalid(axil_bvalid), .bready(axil_bready), .bresp(axil_bresp),
        .arvalid(axil_arvalid), .araddr(axil_araddr), .arready(axil_arready),
        .rvalid(axil_rvalid), .rready(axil_rready), .rdata(axil_rdata), .rresp(axil_rresp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_word(rd_word)
    );

    dma_csr_regs #(
        .LEN_W(LEN_W), .LEN_ALIGN(LEN_ALIGN), .BEAT_W(BEAT_W), .ID_W(ID_W), .FLAG_W(FLAG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_word(rd_word),
        .irq_mask(irq_mask), .irq_pend(irq_pend),
        .mask_we(mask_we), .pend_we(pend_we), .irq_evt(irq_evt),
        .ctrl_enable(ctrl_enable), .req_valid(req_valid), .req_ready(req_ready),
        .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
        .req_x_len(req_x_len), .req_y_len(req_y_len),
        .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
        .req_flags(req_flags), .rsp_valid(rsp_valid), .rsp_eot(rsp_eot)
    );

    dma_csr_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .evt(irq_evt), .mask_we(mask_we), .pend_we(pend_we),
        .wbits(wr_data[IRQ_N-1:0]),
        .mask_q(irq_mask), .pend_q(irq_pend), .irq(irq)
    );
endmodule

// File: tb/dma_csr_top_tb_top.sv
module dma_csr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
    logic        arvalid = 1'b0, rready = 1'b0;
    logic [10:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        ctrl_enable, req_valid, irq;
    logic        req_ready = 1'b0, rsp_valid = 1'b0, rsp_eot = 1'b0;
    logic [31:0] req_dst_addr, req_src_addr;
    logic [23:0] req_x_len, req_y_len, req_dst_stride, req_src_stride;
    logic [2:0]  req_flags;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_csr_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .axil_awvalid(awvalid), .axil_awaddr(awaddr), .axil_awready(awready),
        .axil_wvalid(wvalid), .axil_wdata(wdata), .axil_wready(wready),
        .axil_bvalid(bvalid), .axil_bready(bready), .axil_bresp(bresp),
        .axil_arvalid(arvalid), .axil_araddr(araddr), .axil_arready(arready),
        .axil_rvalid(rvalid), .axil_rready(rready), .axil_rdata(rdata), .axil_rresp(rresp),
        .ctrl_enable(ctrl_enable), .req_valid(req_valid), .req_ready(req_ready),
        .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
        .req_x_len(req_x_len), .req_y_len(req_y_len),
        .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
        .req_flags(req_flags), .rsp_valid(rsp_valid), .rsp_eot(rsp_eot), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // order 0: together, 1: address first, 2: data first
    task automatic axi_write(input logic [10:0] a, input logic [31:0] d, input int order);
        bit aw_done = 0, w_done = 0, aw_hs, w_hs;
        @(negedge clk);
        awaddr = a; wdata = d;
        awvalid = (order != 2);
        wvalid  = (order != 1);
        while (!(aw_done && w_done)) begin
            aw_hs = awvalid && awready;
            w_hs  = wvalid && wready;
            @(negedge clk);
            if (aw_hs) begin aw_done = 1; awvalid = 1'b0; end
            if (w_hs)  begin w_done = 1;  wvalid = 1'b0; end
            if (order == 1 && aw_done && !w_done) wvalid = 1'b1;
            if (order == 2 && w_done && !aw_done) awvalid = 1'b1;
        end
        bready = 1'b1;
        while (!bvalid) @(negedge clk);
        chk("R6", "bresp OKAY", {30'b0, bresp}, 32'h0);
        @(negedge clk);
        bready = 1'b0;
        chk("R7", "single write response", {31'b0, bvalid}, 32'h0);
    endtask

    task automatic axi_read(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1; rready = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        chk("R7", "rvalid one cycle after accept", {31'b0, rvalid}, 32'h1);
        chk("R6", "rresp OKAY", {30'b0, rresp}, 32'h0);
        d = rdata;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [10:0] a, input logic [31:0] exp);
        logic [31:0] v;
        axi_read(a, v);
        chk(req, $sformatf("read 0x%03h", a), v, exp);
    endtask

    task automatic eot_pulse(input logic eot);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_eot = eot;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_eot = 1'b0;
    endtask

    task automatic check_reset_values(input string req);
        logic [10:0] ofs [18] = '{11'h000, 11'h008, 11'h00C, 11'h010, 11'h080, 11'h084,
                                  11'h088, 11'h400, 11'h404, 11'h408, 11'h40C, 11'h410,
                                  11'h414, 11'h418, 11'h41C, 11'h420, 11'h424, 11'h428};
        logic [31:0] val [18] = '{32'h00040361, 32'h0, 32'h444D4143, 32'h00002101, 32'h3, 32'h0,
                                  32'h0, 32'h0, 32'h0, 32'h0, 32'h3, 32'h0,
                                  32'h0, 32'h3, 32'h0, 32'h0, 32'h0, 32'h0};
        for (int i = 0; i < 18; i++) rd_chk(req, ofs[i], val[i]);
        chk(req, "irq after reset", {31'b0, irq}, 32'h0);
        chk(req, "req_valid after reset", {31'b0, req_valid}, 32'h0);
        chk(req, "ctrl_enable after reset", {31'b0, ctrl_enable}, 32'h0);
    endtask

    // R1
    task automatic t_reset_values();
        check_reset_values("R1");
    endtask

    // R2
    task automatic t_scratch_and_ids();
        axi_write(11'h008, 32'h1234_5678, 0);
        rd_chk("R2", 11'h008, 32'h1234_5678);
        axi_write(11'h000, 32'hFFFF_FFFF, 0);
        axi_write(11'h00C, 32'h0, 0);
        rd_chk("R2", 11'h000, 32'h0004_0361);
        rd_chk("R2", 11'h00C, 32'h444D_4143);
    endtask

    // R7
    task automatic t_write_orders();
        axi_write(11'h008, 32'hA5A5_0001, 1);
        rd_chk("R7", 11'h008, 32'hA5A5_0001);
        axi_write(11'h008, 32'h5A5A_0002, 2);
        rd_chk("R7", 11'h008, 32'h5A5A_0002);
    endtask

    // R3 R4 R5
    task automatic t_alignment();
        axi_write(11'h418, 32'h0, 0);
        rd_chk("R3", 11'h418, 32'h3);
        chk("R3", "req_x_len port", {8'h0, req_x_len}, 32'h3);
        axi_write(11'h418, 32'hFFFF_FFFF, 0);
        rd_chk("R3", 11'h418, 32'h00FF_FFFF);
        axi_write(11'h418, 32'h0000_1234, 0);
        rd_chk("R3", 11'h418, 32'h0000_1237);
        axi_write(11'h41C, 32'hFFFF_FFFF, 0);
        rd_chk("R3", 11'h41C, 32'h00FF_FFFF);
        axi_write(11'h410, 32'hFFFF_FFFF, 0);
        rd_chk("R4", 11'h410, 32'hFFFF_FFFE);
        axi_write(11'h414, 32'h1357_9BDF, 0);
        rd_chk("R4", 11'h414, 32'h1357_9BDE);
        axi_write(11'h420, 32'hFFFF_FFFF, 0);
        rd_chk("R4", 11'h420, 32'h00FF_FFFE);
        axi_write(11'h424, 32'h0000_0011, 0);
        rd_chk("R4", 11'h424, 32'h0000_0010);
        chk("R4", "req_src_stride port", {8'h0, req_src_stride}, 32'h10);
        axi_write(11'h40C, 32'hFFFF_FFFD, 0);
        rd_chk("R5", 11'h40C, 32'h5);
        chk("R5", "req_flags port", {29'b0, req_flags}, 32'h5);
    endtask

    // R6
    task automatic t_unmapped();
        axi_write(11'h0FC, 32'hDEAD_BEEF, 0);
        axi_write(11'h500, 32'hDEAD_BEEF, 2);
        rd_chk("R6", 11'h0FC, 32'h0);
        rd_chk("R6", 11'h500, 32'h0);
        rd_chk("R6", 11'h7FC, 32'h0);
        rd_chk("R6", 11'h008, 32'h5A5A_0002);
    endtask

    // R8 R9 R10
    task automatic t_submit();
        axi_write(11'h080, 32'h0, 0);
        axi_write(11'h410, 32'h1000_0000, 0);
        axi_write(11'h418, 32'h3F, 0);
        axi_write(11'h408, 32'h1, 0);
        chk("R8", "req_valid low while disabled", {31'b0, req_valid}, 32'h0);
        axi_write(11'h400, 32'h1, 0);
        chk("R8", "ctrl_enable", {31'b0, ctrl_enable}, 32'h1);
        chk("R8", "req_valid offered", {31'b0, req_valid}, 32'h1);
        chk("R8", "req_dst_addr", req_dst_addr, 32'h1000_0000);
        axi_write(11'h408, 32'h0, 0);
        rd_chk("R8", 11'h408, 32'h1);
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        chk("R8", "req_valid after accept", {31'b0, req_valid}, 32'h0);
        rd_chk("R8", 11'h408, 32'h0);
        rd_chk("R9", 11'h404, 32'h1);
        rd_chk("R9", 11'h428, 32'h8000_0000);
        rd_chk("R10", 11'h084, 32'h1);
        rd_chk("R10", 11'h088, 32'h1);
        chk("R10", "irq on accept", {31'b0, irq}, 32'h1);
        eot_pulse(1'b0);
        rd_chk("R9", 11'h428, 32'h8000_0000);
        rd_chk("R9", 11'h084, 32'h1);
        eot_pulse(1'b1);
        rd_chk("R9", 11'h428, 32'h0);
        rd_chk("R10", 11'h084, 32'h3);
        axi_write(11'h084, 32'h1, 0);
        rd_chk("R10", 11'h084, 32'h2);
        chk("R10", "irq still set", {31'b0, irq}, 32'h1);
        axi_write(11'h084, 32'h2, 0);
        rd_chk("R10", 11'h084, 32'h0);
        chk("R10", "irq cleared", {31'b0, irq}, 32'h0);
        axi_write(11'h080, 32'h3, 0);
        axi_write(11'h408, 32'h1, 0);
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        rd_chk("R10", 11'h084, 32'h1);
        rd_chk("R10", 11'h088, 32'h0);
        chk("R10", "irq masked", {31'b0, irq}, 32'h0);
        rd_chk("R9", 11'h428, 32'h4000_0000);
        eot_pulse(1'b1);
        axi_write(11'h084, 32'h3, 0);
        rd_chk("R9", 11'h428, 32'h0);
    endtask

    // R13 R9
    task automatic t_ids_full();
        @(negedge clk); req_ready = 1'b1;
        for (int i = 0; i < 4; i++) axi_write(11'h408, 32'h1, 0);
        rd_chk("R13", 11'h428, 32'hF000_0000);
        rd_chk("R9", 11'h404, 32'h2);
        axi_write(11'h408, 32'h1, 0);
        chk("R13", "req_valid low with all IDs busy", {31'b0, req_valid}, 32'h0);
        rd_chk("R13", 11'h408, 32'h1);
        @(negedge clk); req_ready = 1'b0;
        eot_pulse(1'b1);
        rd_chk("R9", 11'h428, 32'hD000_0000);
        chk("R13", "req_valid once oldest frees", {31'b0, req_valid}, 32'h1);
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        rd_chk("R13", 11'h428, 32'hF000_0000);
        rd_chk("R13", 11'h404, 32'h3);
        for (int i = 0; i < 4; i++) eot_pulse(1'b1);
        rd_chk("R9", 11'h428, 32'h0);
        axi_write(11'h084, 32'h3, 0);
    endtask

    // R11
    task automatic t_set_wins();
        @(negedge clk); req_ready = 1'b1;
        axi_write(11'h408, 32'h1, 0);
        @(negedge clk); req_ready = 1'b0;
        axi_write(11'h084, 32'h3, 0);
        rd_chk("R11", 11'h084, 32'h0);
        fork
            axi_write(11'h084, 32'h2, 0);
            eot_pulse(1'b1);
        join
        rd_chk("R11", 11'h084, 32'h2);
        rd_chk("R11", 11'h428, 32'h0);
    endtask

    // R12
    task automatic t_reset_all();
        logic [10:0] wofs [14] = '{11'h008, 11'h080, 11'h084, 11'h400, 11'h408, 11'h40C, 11'h410,
                                   11'h414, 11'h418, 11'h41C, 11'h420, 11'h424, 11'h404, 11'h428};
        for (int i = 0; i < 14; i++) axi_write(wofs[i], 32'hFFFF_FFFF, 0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset_values("R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_scratch_and_ids();
        t_write_orders();
        t_alignment();
        t_unmapped();
        t_submit();
        t_ids_full();
        t_set_wins();
        t_reset_all();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule